// File: doc/BRIEF.md
# Lockstep Thread-Group Instruction Sequencer

This block is the control state machine of one compute core that runs a group of threads in lockstep under a single shared program counter. It walks every instruction through six phases: fetch, decode, memory request, memory wait, execute and writeback. It runs no datapath of its own. It drives a fetch request, one memory request per thread, one ALU enable per thread, one register-file write enable per thread and one PC-update enable per thread. It reads a valid flag from the fetcher, instruction-class flags from the decoder, and a per-thread completion pulse from each load/store unit.

A start pulse launches the kernel from the idle state. The memory phases carry a handshake only for load and store instructions. For every other instruction they pass in one cycle each. The next instruction does not begin until the current one has finished on every active thread. A return instruction seen at decode ends the run, and the done output stays high until reset.

Top module: `simt_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the sequencer goes to idle (`phase` = 0). `done`, `fetch_req`, `lsu_req`, `lsu_we`, `alu_en`, `rf_we` and `pc_en` are all low.
- R2: From idle, a high `start` moves `phase` to fetch (1) at the next edge. Without `start` the sequencer stays idle. `start` is ignored in every other phase.
- R3: In fetch (`phase` = 1), `fetch_req` is high and the phase holds until `fetch_valid` is sampled high.
- R4: The phase codes are idle 0, fetch 1, decode 2, request 3, wait 4, execute 5, update 6, done 7. Decode lasts exactly one cycle, and the decoder flags are sampled in that cycle.
- R5: In request (3), for a load or a store, `lsu_req` equals `active_mask` for exactly one cycle and `lsu_we` is high only for a store. For other instructions `lsu_req` and `lsu_we` stay low.
- R6: For a load or a store, wait (4) holds until every thread set in `active_mask` has pulsed `lsu_done` during a wait cycle. Pulses may land in different cycles and are remembered. A pulse seen in the request cycle is not counted, and threads outside the mask are not waited for.
- R7: For an instruction that is neither load nor store, request and wait take one cycle each.
- R8: Execute (5) drives `alu_en` = `active_mask` for one cycle. Update (6) drives `rf_we` and `pc_en` = `active_mask` for one cycle and then returns to fetch.
- R9: If `dec_is_ret` is high in decode, the next phase is done (7). `done` then stays high, and `start` has no effect, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches the kernel from idle |
| active_mask | input | NT | Threads taking part in the group |
| fetch_valid | input | 1 | Fetcher has the instruction ready |
| dec_is_load | input | 1 | Decoded instruction is a load |
| dec_is_store | input | 1 | Decoded instruction is a store |
| dec_is_ret | input | 1 | Decoded instruction ends the kernel |
| lsu_done | input | NT | Per-thread memory completion pulse |
| fetch_req | output | 1 | Request to the fetcher |
| lsu_req | output | NT | Per-thread memory request |
| lsu_we | output | 1 | Memory request is a write |
| alu_en | output | NT | Per-thread ALU enable |
| rf_we | output | NT | Per-thread register file and condition-flag write |
| pc_en | output | NT | Per-thread PC update enable |
| phase | output | 3 | Current phase code |
| done | output | 1 | Kernel finished |

## Verification
Two of the block's functions can fall in the same cycle: remembering an early thread completion, and seeing the last outstanding completion. The second decides when wait exits. The bench provokes this with load and store vectors whose per-thread completion cycles coincide, are staggered in both directions, or leave masked threads silent. It judges each vector by the exact cycle in which execute appears. A further case pulses one thread in the request cycle itself, where the pulse must not be counted, so wait must run until that thread pulses again.

// File: rtl/simt_seq_pkg.sv
// Package: shared phase encoding of the thread-group sequencer.
// Assumes: a 3-bit phase code is observed at the block's ports.
package simt_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FETCH  = 3'd1,
        PH_DECODE = 3'd2,
        PH_REQ    = 3'd3,
        PH_WAIT   = 3'd4,
        PH_EXEC   = 3'd5,
        PH_UPDATE = 3'd6,
        PH_DONE   = 3'd7
    } phase_e;

endpackage

// File: rtl/simt_seq_track.sv
// Module: per-thread memory completion tracker.
// Remembers each thread's completion pulse while the sequencer waits and
// reports when every active thread has completed. Assumes pulses outside
// the wait phase are stale and must be discarded.
module simt_seq_track #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_wait,
    input  logic [NT-1:0] mask,
    input  logic [NT-1:0] lsu_done,
    output logic          all_done
);

    logic [NT-1:0] seen_q;
    logic [NT-1:0] thr_ok;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // Sticky completion flag for one thread, cleared outside wait.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q[t] <= 1'b0;
            end else if (in_wait) begin
                seen_q[t] <= seen_q[t] | lsu_done[t];
            end else begin
                seen_q[t] <= 1'b0;
            end
        end

        // A thread is satisfied if inactive, already seen, or completing now.
        always_comb begin
            thr_ok[t] = ~mask[t] | seen_q[t] | (in_wait & lsu_done[t]);
        end
    end

    // Reduce the per-thread status to one release flag.
    always_comb begin
        all_done = &thr_ok;
    end

endmodule

// File: rtl/simt_seq_ctrl.sv
// Module: phase state machine of the sequencer.
// Steps idle -> fetch -> decode -> request -> wait -> execute -> update and
// back to fetch, leaves decode for done on a return instruction, and latches
// the instruction class in decode. Assumes decoder flags are valid in decode.
module simt_seq_ctrl
    import simt_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   fetch_valid,
    input  logic   dec_is_load,
    input  logic   dec_is_store,
    input  logic   dec_is_ret,
    input  logic   all_done,
    output phase_e phase,
    output logic   mem_q,
    output logic   store_q
);

    phase_e phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase;
        unique case (phase)
            PH_IDLE:   if (start) phase_d = PH_FETCH;
            PH_FETCH:  if (fetch_valid) phase_d = PH_DECODE;
            PH_DECODE: phase_d = dec_is_ret ? PH_DONE : PH_REQ;
            PH_REQ:    phase_d = PH_WAIT;
            PH_WAIT:   if (!mem_q || all_done) phase_d = PH_EXEC;
            PH_EXEC:   phase_d = PH_UPDATE;
            PH_UPDATE: phase_d = PH_FETCH;
            PH_DONE:   phase_d = PH_DONE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_d;
        end
    end

    // Instruction class latched during decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q   <= 1'b0;
            store_q <= 1'b0;
        end else if (phase == PH_DECODE) begin
            mem_q   <= dec_is_load | dec_is_store;
            store_q <= dec_is_store;
        end
    end

endmodule

// File: rtl/simt_seq_drive.sv
// Module: enable generator of the sequencer.
// Decodes the phase into fetch, memory, ALU, writeback and PC enables,
// gated per thread by the active mask. Purely combinational.
module simt_seq_drive
    import simt_seq_pkg::*;
#(
    parameter int NT = 4
) (
    input  phase_e        phase,
    input  logic          mem_q,
    input  logic          store_q,
    input  logic [NT-1:0] mask,
    output logic          fetch_req,
    output logic          lsu_we,
    output logic [NT-1:0] lsu_req,
    output logic [NT-1:0] alu_en,
    output logic [NT-1:0] rf_we,
    output logic [NT-1:0] pc_en,
    output logic          done
);

    logic mem_go;

    // Group-wide strobes.
    always_comb begin
        mem_go    = (phase == PH_REQ) && mem_q;
        fetch_req = (phase == PH_FETCH);
        lsu_we    = mem_go && store_q;
        done      = (phase == PH_DONE);
    end

    for (genvar t = 0; t < NT; t++) begin : g_en
        // Per-thread enables for one lane.
        always_comb begin
            lsu_req[t] = mask[t] & mem_go;
            alu_en[t]  = mask[t] & (phase == PH_EXEC);
            rf_we[t]   = mask[t] & (phase == PH_UPDATE);
            pc_en[t]   = mask[t] & (phase == PH_UPDATE);
        end
    end

endmodule

// File: rtl/simt_seq.sv
// Module: lockstep thread-group instruction sequencer (top).
// Runs all threads of one core through each instruction phase together and
// waits for every active load/store unit before moving on. Assumes
// active_mask stays stable while an instruction is in flight.
module simt_seq
    import simt_seq_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NT-1:0] active_mask,
    input  logic          fetch_valid,
    input  logic          dec_is_load,
    input  logic          dec_is_store,
    input  logic          dec_is_ret,
    input  logic [NT-1:0] lsu_done,
    output logic          fetch_req,
    output logic [NT-1:0] lsu_req,
    output logic          lsu_we,
    output logic [NT-1:0] alu_en,
    output logic [NT-1:0] rf_we,
    output logic [NT-1:0] pc_en,
    output logic [2:0]    phase,
    output logic          done
);

    phase_e ph;
    logic   mem_q;
    logic   store_q;
    logic   all_done;

    simt_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fetch_valid  (fetch_valid),
        .dec_is_load  (dec_is_load),
        .dec_is_store (dec_is_store),
        .dec_is_ret   (dec_is_ret),
        .all_done     (all_done),
        .phase        (ph),
        .mem_q        (mem_q),
        .store_q      (store_q)
    );

    simt_seq_track #(.NT(NT)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_wait  (ph == PH_WAIT),
        .mask     (active_mask),
        .lsu_done (lsu_done),
        .all_done (all_done)
    );

    simt_seq_drive #(.NT(NT)) u_drive (
        .phase     (ph),
        .mem_q     (mem_q),
        .store_q   (store_q),
        .mask      (active_mask),
        .fetch_req (fetch_req),
        .lsu_we    (lsu_we),
        .lsu_req   (lsu_req),
        .alu_en    (alu_en),
        .rf_we     (rf_we),
        .pc_en     (pc_en),
        .done      (done)
    );

    // Phase code brought out to the port.
    always_comb begin
        phase = ph;
    end

endmodule

// File: rtl/simt_seq_chk.sv
// Module: protocol checker for the sequencer, bound to the top module.
// Observes ports only and flags illegal phase steps or enable patterns.
module simt_seq_chk #(
    parameter int NT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NT-1:0] active_mask,
    input logic          fetch_valid,
    input logic          fetch_req,
    input logic [NT-1:0] lsu_req,
    input logic [NT-1:0] alu_en,
    input logic [NT-1:0] rf_we,
    input logic [2:0]    phase,
    input logic          done
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (phase == 3'd0 && !done && !fetch_req && lsu_req == '0));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && start) |=> phase == 3'd1);

    p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && !fetch_valid) |=> phase == 3'd1);

    p_decode_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd2 |=> (phase == 3'd3 || phase == 3'd7));

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lsu_req != '0) |=> (lsu_req == '0 && phase == 3'd4));

    p_exec_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd5 |-> $past(phase) == 3'd4);

    p_nonmem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && lsu_req == '0) |=> phase == 3'd4 ##1 phase == 3'd5);

    p_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd6 |=> phase == 3'd1);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, |lsu_req, |alu_en, |rf_we}));

    p_lane_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_en | rf_we) & ~active_mask) == '0);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && phase == 3'd7));

endmodule

bind simt_seq simt_seq_chk #(.NT(NT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .active_mask (active_mask),
    .fetch_valid (fetch_valid),
    .fetch_req   (fetch_req),
    .lsu_req     (lsu_req),
    .alu_en      (alu_en),
    .rf_we       (rf_we),
    .phase       (phase),
    .done        (done)
);

// File: tb/simt_seq_tb.sv
module simt_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NVEC = 8;

    // Vector: {load, store, mask[3:0], fetch_delay[3:0], d3, d2, d1, d0}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 4'hF, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {1'b0, 1'b0, 4'hF, 4'd3, 3'd0, 3'd0, 3'd0, 3'd0},
        {1'b1, 1'b0, 4'hF, 4'd0, 3'd2, 3'd2, 3'd2, 3'd2},
        {1'b0, 1'b1, 4'hF, 4'd1, 3'd3, 3'd2, 3'd1, 3'd0},
        {1'b1, 1'b0, 4'hF, 4'd0, 3'd0, 3'd1, 3'd2, 3'd4},
        {1'b1, 1'b0, 4'h5, 4'd0, 3'd7, 3'd1, 3'd7, 3'd3},
        {1'b0, 1'b1, 4'h0, 4'd2, 3'd7, 3'd7, 3'd7, 3'd7},
        {1'b0, 1'b0, 4'h3, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NT-1:0] active_mask = '0;
    logic          fetch_valid = 1'b0;
    logic          dec_is_load = 1'b0;
    logic          dec_is_store = 1'b0;
    logic          dec_is_ret = 1'b0;
    logic [NT-1:0] lsu_done = '0;
    logic          fetch_req;
    logic [NT-1:0] lsu_req;
    logic          lsu_we;
    logic [NT-1:0] alu_en;
    logic [NT-1:0] rf_we;
    logic [NT-1:0] pc_en;
    logic [2:0]    phase;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    simt_seq #(.NT(NT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .active_mask  (active_mask),
        .fetch_valid  (fetch_valid),
        .dec_is_load  (dec_is_load),
        .dec_is_store (dec_is_store),
        .dec_is_ret   (dec_is_ret),
        .lsu_done     (lsu_done),
        .fetch_req    (fetch_req),
        .lsu_req      (lsu_req),
        .lsu_we       (lsu_we),
        .alu_en       (alu_en),
        .rf_we        (rf_we),
        .pc_en        (pc_en),
        .phase        (phase),
        .done         (done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_quiet(input string tag);
        chk(phase == 3'd0, tag, int'(phase), 0);
        chk(done == 1'b0 && fetch_req == 1'b0 && lsu_we == 1'b0, tag,
            int'({done, fetch_req, lsu_we}), 0);
        chk(lsu_req == '0 && alu_en == '0 && rf_we == '0 && pc_en == '0, tag,
            int'({lsu_req, alu_en, rf_we, pc_en}), 0);
    endtask

    // Launch from idle; called at a falling edge.
    task automatic launch();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(phase == 3'd1, "R2 start to fetch", int'(phase), 1);
    endtask

    // One instruction; entered at a falling edge while in fetch.
    task automatic run_instr(input logic ld, input logic st, input logic rt,
                             input logic [NT-1:0] mk, input int fd,
                             input logic [11:0] dly, input logic early0);
        int  wlen;
        logic mem;
        mem = ld | st;
        active_mask = mk;
        for (int c = 0; c <= fd; c++) begin
            chk(phase == 3'd1, "R3 fetch hold", int'(phase), 1);
            chk(fetch_req == 1'b1, "R3 fetch_req", int'(fetch_req), 1);
            fetch_valid = (c == fd);
            if (c == fd) begin
                dec_is_load  = ld;
                dec_is_store = st;
                dec_is_ret   = rt;
            end
            @(negedge clk);
        end
        fetch_valid = 1'b0;
        chk(phase == 3'd2, "R4 decode", int'(phase), 2);
        chk(fetch_req == 1'b0, "R4 decode no fetch", int'(fetch_req), 0);
        @(negedge clk);
        dec_is_load  = 1'b0;
        dec_is_store = 1'b0;
        dec_is_ret   = 1'b0;
        if (rt) begin
            chk(phase == 3'd7, "R9 ret to done", int'(phase), 7);
            chk(done == 1'b1, "R9 done high", int'(done), 1);
            return;
        end
        chk(phase == 3'd3, "R4 request", int'(phase), 3);
        chk(lsu_req == (mem ? mk : '0), "R5 lsu_req", int'(lsu_req), int'(mem ? mk : '0));
        chk(lsu_we == (mem & st), "R5 lsu_we", int'(lsu_we), int'(mem & st));
        if (early0) lsu_done = 4'b0001;
        @(negedge clk);
        lsu_done = '0;
        wlen = 1;
        if (mem) begin
            for (int t = 0; t < NT; t++) begin
                if (mk[t] && int'(dly[3*t +: 3]) + 1 > wlen) wlen = int'(dly[3*t +: 3]) + 1;
            end
        end
        for (int j = 0; j < wlen; j++) begin
            chk(phase == 3'd4, mem ? "R6 wait hold" : "R7 wait one cycle", int'(phase), 4);
            chk(lsu_req == '0, "R5 request single cycle", int'(lsu_req), 0);
            if (mem) begin
                for (int t = 0; t < NT; t++) lsu_done[t] = (int'(dly[3*t +: 3]) == j);
            end
            @(negedge clk);
        end
        lsu_done = '0;
        chk(phase == 3'd5, mem ? "R6 wait exit" : "R7 execute", int'(phase), 5);
        chk(alu_en == mk, "R8 alu_en", int'(alu_en), int'(mk));
        chk(rf_we == '0, "R8 no write in execute", int'(rf_we), 0);
        @(negedge clk);
        chk(phase == 3'd6, "R8 update", int'(phase), 6);
        chk(rf_we == mk && pc_en == mk, "R8 rf_we pc_en", int'({rf_we, pc_en}), int'({mk, mk}));
        chk(alu_en == '0, "R8 alu off in update", int'(alu_en), 0);
        @(negedge clk);
        chk(phase == 3'd1, "R8 back to fetch", int'(phase), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_quiet("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle holds without start
        repeat (3) @(negedge clk);
        chk(phase == 3'd0, "R2 idle holds", int'(phase), 0);

        launch();
        for (int v = 0; v < NVEC; v++) begin
            run_instr(VEC[v][21], VEC[v][20], 1'b0, VEC[v][19:16],
                      int'(VEC[v][15:12]), VEC[v][11:0], 1'b0);
        end

        // R6: pulse in the request cycle is not counted
        run_instr(1'b1, 1'b0, 1'b0, 4'hF, 0, {3'd0, 3'd0, 3'd0, 3'd2}, 1'b1);

        // R2: start during an instruction is ignored
        start = 1'b1;
        run_instr(1'b0, 1'b0, 1'b0, 4'hF, 1, 12'd0, 1'b0);
        start = 1'b0;

        // R9: return ends the run; start ignored in done
        run_instr(1'b0, 1'b0, 1'b1, 4'hF, 0, 12'd0, 1'b0);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        chk(phase == 3'd7, "R9 done holds under start", int'(phase), 7);
        chk(done == 1'b1, "R9 done sticky", int'(done), 1);

        // R1: reset from done
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1 reset from done");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset in the middle of a memory wait
        launch();
        active_mask = 4'hF;
        fetch_valid = 1'b1;
        dec_is_load = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0;
        @(negedge clk);
        dec_is_load = 1'b0;
        @(negedge clk);
        chk(phase == 3'd4, "R6 in wait before reset", int'(phase), 4);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1 reset in wait");
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 3'd0, "R2 idle after reset", int'(phase), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule